// File: doc/BRIEF.md
# Nonce-Sealed Message Sender

This block turns a 14-bit command payload into a short authenticated frame. It keeps a 32-bit message counter used as a nonce. For each message it builds one 64-bit block from the nonce, a fixed run of zero bits and the payload. It enciphers that block with an iterative TEA datapath under a 128-bit key that is fixed at build time. A receiver that deciphers the block and finds its own copy of the clear nonce and the zero run can accept the payload. The redundant bits inside the sealed block take the place of a separate MAC field.

A controller presents a header byte and a payload and pulses `start`. The block then runs the cipher one round per clock. It streams a 13-byte frame over a valid/ready byte interface: the header, the nonce in the clear, then the ciphertext. A build-time option also seals the header inside the block. The nonce advances only once the whole frame has been accepted downstream.

Top module: `sealed_msg_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `out_valid` and `done` are low.
- R2: With header sealing off, the enciphered block is the nonce in bits 63:32, zeros in bits 31:14 and the payload in bits 13:0.
- R3: With header sealing on, the enciphered block is the header in bits 63:56, the nonce in bits 55:24, zeros in bits 23:14 and the payload in bits 13:0.
- R4: Encryption is TEA with a 32-bit left half taken from block bits 63:32. The key words come from key bits 127:96, 95:64, 63:32 and 31:0 in that order. The running sum is increased by 0x9E3779B9 before each of ROUNDS rounds.
- R5: A frame is exactly 13 bytes: the header byte, the four nonce bytes, then the eight ciphertext bytes. Each multi-byte field is sent most significant byte first.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. A byte is consumed only on a clock edge where both are high.
- R7: The first frame byte becomes valid exactly ROUNDS+1 clock edges after the edge that accepts `start`.
- R8: A `start` pulse while `busy` is high has no effect. The frame in progress keeps its latched header and payload, and no extra frame follows.
- R9: `busy` rises at the edge that accepts `start` and falls at the edge that consumes the last byte. `done` is high for exactly the one cycle that follows that edge.
- R10: The nonce starts at NONCE_INIT after reset. It advances by one modulo 2^32 only when a frame completes, so consecutive frames carry consecutive nonces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to seal and send one message; sampled only when idle |
| hdr | input | 8 | Header byte for the message |
| payload | input | 14 | Command payload |
| busy | output | 1 | A message is being enciphered or sent |
| out_valid | output | 1 | Frame byte on `out_data` is valid |
| out_data | output | 8 | Current frame byte |
| out_ready | input | 1 | Downstream accepts the current byte |
| done | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
The bench builds two copies of the block side by side, one with header sealing off and one with it on. Both use the full 32 rounds and a nonce that starts three below the 32-bit wrap point. This starting value brings the nonce rollover into reach within the first few frames. It also lets both block layouts be checked against the same stimulus and the same arithmetic TEA model. Payloads sweep a walking-one set, the all-zero and all-one corners and a strided spread of values, while the header also varies. Stalls on `out_ready` and stray `start` pulses during the cipher and send phases are mixed in.

// File: rtl/seal_pkg.sv
package seal_pkg;

  localparam int BLK_W     = 64;
  localparam int HALF_W    = BLK_W / 2;
  localparam int KEY_W     = 128;
  localparam int NONCE_W   = 32;
  localparam int PAY_W     = 14;
  localparam int HDR_W     = 8;
  localparam int BYTE_W    = 8;
  localparam int PAD_PLAIN = BLK_W - NONCE_W - PAY_W;
  localparam int PAD_AUTH  = BLK_W - HDR_W - NONCE_W - PAY_W;
  localparam int FRAME_BYTES = (HDR_W + NONCE_W + BLK_W) / BYTE_W;
  localparam logic [HALF_W-1:0] TEA_DELTA = 32'h9E37_79B9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CIPH = 2'd1,
    ST_SEND = 2'd2
  } tx_state_e;

  // nonce | zeros | payload
  function automatic logic [BLK_W-1:0] pack_plain(
    input logic [NONCE_W-1:0] n,
    input logic [PAY_W-1:0]   p
  );
    return {n, {PAD_PLAIN{1'b0}}, p};
  endfunction

  // header | nonce | zeros | payload
  function automatic logic [BLK_W-1:0] pack_auth(
    input logic [HDR_W-1:0]   h,
    input logic [NONCE_W-1:0] n,
    input logic [PAY_W-1:0]   p
  );
    return {h, n, {PAD_AUTH{1'b0}}, p};
  endfunction

  // One full TEA round: both Feistel halves, using the already advanced sum.
  function automatic logic [BLK_W-1:0] tea_step(
    input logic [BLK_W-1:0]  v,
    input logic [HALF_W-1:0] s,
    input logic [KEY_W-1:0]  k
  );
    logic [HALF_W-1:0] lo_h, hi_h;
    hi_h = v[BLK_W-1:HALF_W];
    lo_h = v[HALF_W-1:0];
    hi_h = hi_h + (((lo_h << 4) + k[127:96]) ^ (lo_h + s) ^ ((lo_h >> 5) + k[95:64]));
    lo_h = lo_h + (((hi_h << 4) + k[63:32])  ^ (hi_h + s) ^ ((hi_h >> 5) + k[31:0]));
    return {hi_h, lo_h};
  endfunction

endpackage

// File: rtl/seal_nonce_ctr.sv
module seal_nonce_ctr #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);

  logic [W-1:0] value_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= INIT;
    end else if (step) begin
      value_q <= value_q + W'(1);
    end
  end

  assign value = value_q;

endmodule

// File: rtl/seal_tea_core.sv
module seal_tea_core
  import seal_pkg::*;
#(
  parameter int               ROUNDS = 32,
  parameter logic [KEY_W-1:0] KEY    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] blk_in,
  output logic [BLK_W-1:0] blk_out,
  output logic             fin
);

  localparam int CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CW-1:0] LAST_RND = CW'(ROUNDS - 1);

  logic [BLK_W-1:0]  v_q;
  logic [HALF_W-1:0] sum_q;
  logic [HALF_W-1:0] sum_nxt;
  logic [CW-1:0]     cnt_q;
  logic              run_q;
  logic              fin_q;
  logic              round_last;

  assign sum_nxt    = sum_q + TEA_DELTA;
  assign round_last = run_q && (cnt_q == LAST_RND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      sum_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= round_last;
      if (load) begin
        v_q   <= blk_in;
        sum_q <= '0;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        v_q   <= tea_step(v_q, sum_nxt, KEY);
        sum_q <= sum_nxt;
        cnt_q <= cnt_q + CW'(1);
        if (round_last) begin
          run_q <= 1'b0;
        end
      end
    end
  end

  assign blk_out = v_q;
  assign fin     = fin_q;

endmodule

// File: rtl/seal_byte_ser.sv
module seal_byte_ser
  import seal_pkg::*;
#(
  parameter int NBYTES = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [NBYTES*BYTE_W-1:0] frame,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [BYTE_W-1:0]        out_data,
  output logic                     fire,
  output logic                     last_fire
);

  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);

  logic [BYTE_W-1:0] lane [NBYTES];
  logic [IW-1:0]     idx_q;
  logic              act_q;

  // Byte 0 is the most significant byte of the frame vector.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = frame[(NBYTES-1-g)*BYTE_W +: BYTE_W];
  end

  assign fire      = act_q && out_ready;
  assign last_fire = fire && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (go) begin
      idx_q <= '0;
      act_q <= 1'b1;
    end else if (fire) begin
      idx_q <= idx_q + IW'(1);
      if (last_fire) begin
        act_q <= 1'b0;
      end
    end
  end

  assign out_valid = act_q;
  assign out_data  = lane[idx_q];

endmodule

// File: rtl/sealed_msg_tx.sv
module sealed_msg_tx
  import seal_pkg::*;
#(
  parameter int                 ROUNDS     = 32,
  parameter logic [KEY_W-1:0]   KEY        = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0,
  parameter bit                 HDR_AUTH   = 1'b0,
  parameter logic [NONCE_W-1:0] NONCE_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HDR_W-1:0]  hdr,
  input  logic [PAY_W-1:0]  payload,
  output logic              busy,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              done
);

  localparam int FRAME_W = FRAME_BYTES * BYTE_W;

  tx_state_e            state_q;
  logic                 accept;
  logic                 cipher_fin;
  logic                 ser_go;
  logic                 byte_fire;
  logic                 frame_last;
  logic                 done_q;
  logic [NONCE_W-1:0]   nonce_val;
  logic [HDR_W-1:0]     hdr_q;
  logic [BLK_W-1:0]     plain_blk;
  logic [BLK_W-1:0]     cipher_blk;
  logic [FRAME_W-1:0]   frame_vec;

  assign accept = start && (state_q == ST_IDLE);
  assign ser_go = cipher_fin && (state_q == ST_CIPH);

  if (HDR_AUTH) begin : g_blk_auth
    assign plain_blk = pack_auth(hdr, nonce_val, payload);
  end else begin : g_blk_plain
    assign plain_blk = pack_plain(nonce_val, payload);
  end

  assign frame_vec = {hdr_q, nonce_val, cipher_blk};

  seal_nonce_ctr #(
    .W    (NONCE_W),
    .INIT (NONCE_INIT)
  ) u_nonce (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (frame_last),
    .value (nonce_val)
  );

  seal_tea_core #(
    .ROUNDS (ROUNDS),
    .KEY    (KEY)
  ) u_tea (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .blk_in  (plain_blk),
    .blk_out (cipher_blk),
    .fin     (cipher_fin)
  );

  seal_byte_ser #(
    .NBYTES (FRAME_BYTES)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (ser_go),
    .frame     (frame_vec),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .fire      (byte_fire),
    .last_fire (frame_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= frame_last;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_CIPH;
          hdr_q   <= hdr;
        end
        ST_CIPH: if (cipher_fin) state_q <= ST_SEND;
        ST_SEND: if (frame_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

endmodule

// File: rtl/seal_tx_checker.sv
module seal_tx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        out_valid,
  input logic [7:0]  out_data,
  input logic        out_ready,
  input logic        done,
  input logic        cipher_fin,
  input logic [31:0] nonce_q
);

  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_valid_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_nonce_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nonce_q == $past(nonce_q) + 32'd1));

  p_nonce_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(nonce_q));

  p_start_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_first_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(cipher_fin));

endmodule

bind sealed_msg_tx seal_tx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_ready  (out_ready),
  .done       (done),
  .cipher_fin (cipher_fin),
  .nonce_q    (nonce_val)
);

// File: tb/tb_sealed_msg_tx.sv
`timescale 1ns/1ps
module tb_sealed_msg_tx;

  localparam int           ROUNDS = 32;
  localparam logic [127:0] KEY    = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [31:0]  NINIT  = 32'hFFFF_FFFD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  hdr = '0;
  logic [13:0] payload = '0;
  logic        out_ready = 1'b0;
  logic        busy, out_valid, done;
  logic [7:0]  out_data;
  logic        busy_h, valid_h, done_h;
  logic [7:0]  data_h;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] exp_nonce;
  logic [7:0]  got_a [13];
  logic [7:0]  got_b [13];

  always #5 clk = ~clk;

  sealed_msg_tx #(.ROUNDS(ROUNDS), .KEY(KEY), .HDR_AUTH(1'b0), .NONCE_INIT(NINIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hdr(hdr), .payload(payload),
    .busy(busy), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .done(done));

  sealed_msg_tx #(.ROUNDS(ROUNDS), .KEY(KEY), .HDR_AUTH(1'b1), .NONCE_INIT(NINIT)) dut_ha (
    .clk(clk), .rst_n(rst_n), .start(start), .hdr(hdr), .payload(payload),
    .busy(busy_h), .out_valid(valid_h), .out_data(data_h),
    .out_ready(out_ready), .done(done_h));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference TEA written from the requirement (R4).
  function automatic logic [63:0] ref_tea(input logic [63:0] p);
    logic [31:0] kw [4];
    logic [31:0] a, b, s;
    for (int i = 0; i < 4; i++) kw[i] = KEY[127 - 32*i -: 32];
    a = p[63:32];
    b = p[31:0];
    s = 32'd0;
    for (int r = 0; r < ROUNDS; r++) begin
      s = s + 32'h9E3779B9;
      a = a + ((( b << 4) + kw[0]) ^ (b + s) ^ ((b >> 5) + kw[1]));
      b = b + ((( a << 4) + kw[2]) ^ (a + s) ^ ((a >> 5) + kw[3]));
    end
    return {a, b};
  endfunction

  task automatic send_msg(input logic [7:0] h, input logic [13:0] pl, input bit stall, input bit poke);
    int n, k, idx;
    bit hold_pend;
    logic [7:0] held;
    logic [63:0] ct_a, ct_b, exp_a, exp_b;
    logic [31:0] nn_a, nn_b;
    @(negedge clk);
    chk(!busy && !busy_h, "R9 idle before start", {63'd0, busy}, 64'd0);
    hdr = h; payload = pl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    hdr = ~h; payload = ~pl;
    chk(busy && busy_h, "R9 busy after start", {63'd0, busy}, 64'd1);
    n = 0;
    while (!out_valid && n < 500) begin
      if (poke && n == 3) begin start = 1'b1; payload = pl ^ 14'h2AAA; hdr = h ^ 8'h5A; end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk(n == ROUNDS + 1, "R7 first byte latency", 64'(n), 64'(ROUNDS + 1));
    k = 0; idx = 0; hold_pend = 1'b0; held = '0;
    while (idx < 13 && k < 500) begin
      out_ready = stall ? ((k % 3) != 1) : 1'b1;
      if (poke && k == 0) begin start = 1'b1; payload = pl ^ 14'h1555; end
      if (out_valid && out_ready) begin
        got_a[idx] = out_data;
        got_b[idx] = data_h;
        idx++;
      end else if (out_valid) begin
        held = out_data;
        hold_pend = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      k++;
      if (hold_pend) begin
        chk(out_valid && out_data == held, "R6 byte held under stall", {56'd0, out_data}, {56'd0, held});
        hold_pend = 1'b0;
      end
    end
    out_ready = 1'b0;
    chk(done && done_h && !busy, "R9 done pulse at end", {62'd0, done, busy}, 64'd2);
    @(negedge clk);
    chk(!done && !out_valid && !busy, "R8 R9 no extra frame", {61'd0, done, out_valid, busy}, 64'd0);
    ct_a = '0; ct_b = '0; nn_a = '0; nn_b = '0;
    for (int i = 1; i < 5; i++) begin
      nn_a = {nn_a[23:0], got_a[i]};
      nn_b = {nn_b[23:0], got_b[i]};
    end
    for (int i = 5; i < 13; i++) begin
      ct_a = {ct_a[55:0], got_a[i]};
      ct_b = {ct_b[55:0], got_b[i]};
    end
    exp_a = ref_tea({exp_nonce, 18'd0, pl});
    exp_b = ref_tea({h, exp_nonce, 10'd0, pl});
    chk(got_a[0] == h && got_b[0] == h, "R5 header byte", {48'd0, got_a[0], got_b[0]}, {48'd0, h, h});
    chk(nn_a == exp_nonce && nn_b == exp_nonce, "R10 nonce field", {nn_a, nn_b}, {exp_nonce, exp_nonce});
    chk(ct_a == exp_a, "R2 R4 R5 ciphertext", ct_a, exp_a);
    chk(ct_b == exp_b, "R3 sealed-header ciphertext", ct_b, exp_b);
    exp_nonce = exp_nonce + 32'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_nonce = NINIT;
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 state in reset", {61'd0, busy, out_valid, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid && !done && !busy_h && !valid_h, "R1 state after reset",
        {61'd0, busy, out_valid, done}, 64'd0);
    send_msg(8'hA5, 14'h0000, 1'b0, 1'b0);
    send_msg(8'h3C, 14'h3FFF, 1'b1, 1'b1);
    send_msg(8'h00, 14'h1234, 1'b0, 1'b1);
    send_msg(8'hFF, 14'h0001, 1'b1, 1'b0);
    for (int b = 0; b < 14; b++) begin
      send_msg(8'(b * 19 + 7), 14'(1 << b), b[0], (b % 4) == 2);
    end
    for (int i = 0; i < 48; i++) begin
      send_msg(8'(i * 37), 14'((i * 613 + 5) & 16'h3FFF), i[0], (i % 5) == 0);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule